// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is an eight-pin general-purpose I/O port behind a plain synchronous register interface. The interface has an address, write data, a write strobe, a read strobe and registered read data. Software sets each pin's direction and its polarity inversion, which acts on both input and output. Software also chooses whether a pin drives a steady level or a self-clearing pulse. The pin-side outputs are a drive value and a drive enable for each pin. A separate register keeps a snapshot of the pins, taken after power-on and, if enabled, while an external reset line is held low.

Inputs pass through a two-flop synchronizer before any other logic sees them. Each pin has a small pulse channel state machine with two states. `CH_IDLE` holds the stored output bit. `CH_ACTIVE` counts out a one-shot pulse. Its transitions are: start (a pulse-style write of 1, from idle to active), restart (another pulse-style write of 1 while active, which stays active with the count cleared), expire (the count reaches `PULSE_LEN`, back to idle with the bit cleared) and abort (a write of 0 or a switch to level style, back to idle). The snapshot state machine moves through `SNAP_FILL1` → `SNAP_FILL2` → `SNAP_TAKE` → `SNAP_IDLE` after reset. The fill states let the synchronizer settle, and `SNAP_TAKE` takes the power-on sample. From `SNAP_IDLE` it enters `SNAP_FOLLOW` when capture is enabled and the synchronized external reset line is low. It returns to `SNAP_IDLE` when either of those conditions goes away.

Register map, 3-bit address: 0 pin input (read-only), 1 output data, 2 polarity, 3 direction, 4 output style, 5 snapshot (read-only), 6 and 7 reserved.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output data register reads 0x00, polarity reads 0xF0, direction reads 0xFF, style reads 0x00, and every pin drive enable is 0.
- R2: A read of address 0 returns, for each bit n, the level of pin n after two synchronizer flops, XOR polarity bit n.
- R3: Address 1 is read/write, and a read returns the stored output bit, not the pin level.
- R4: Each pin's drive value is its stored output bit XOR its polarity bit.
- R5: Direction bit n = 1 makes pin n an input with drive enable 0; direction bit n = 0 makes it an output with drive enable 1. The enable changes on the clock edge that takes the write.
- R6: With style bit n = 0, a written output bit stays driven until it is rewritten.
- R7: With style bit n = 1, writing 1 to output bit n drives the active level for exactly `PULSE_LEN` cycles (default 4), starting at the write edge. The stored bit then clears by itself.
- R8: Address 5 reads the synchronized pin values captured on the third clock edge after reset release, and it holds them while no capture is active.
- R9: With `ext_cap_en` = 1, address 5 follows the synchronized pins while `ext_rst_n` is low. With `ext_cap_en` = 0, `ext_rst_n` has no effect on it.
- R10: Reads of addresses 6 and 7 return 0x00. Writes to addresses 0, 5, 6 and 7 change no register.
- R11: Read data is registered. It is valid on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on/system reset |
| ext_rst_n | input | 1 | Active-low external reset line that triggers a snapshot |
| ext_cap_en | input | 1 | Enables snapshot capture on `ext_rst_n` |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
A register write takes effect on the edge that samples the strobe. Drive enables and drive values therefore change on that edge, and read data is due one edge after the read strobe. A pin change reaches the input register after two edges. It reaches the snapshot in follow mode after three to four edges, because the external line also goes through a synchronizer. The bench drives inputs on falling edges and samples results on falling edges. Before every read it waits at least three cycles after changing pins or the external line. The pulse check samples the pin on each falling edge after the write, expects exactly `PULSE_LEN` high samples, and then reads the self-cleared bit back.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PIN   = 3'd0;
    localparam logic [ADDR_W-1:0] A_OUT   = 3'd1;
    localparam logic [ADDR_W-1:0] A_POL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STYLE = 3'd4;
    localparam logic [ADDR_W-1:0] A_SNAP  = 3'd5;

    typedef enum logic {
        CH_IDLE,
        CH_ACTIVE
    } ch_state_t;

    typedef enum logic [2:0] {
        SNAP_FILL1,
        SNAP_FILL2,
        SNAP_TAKE,
        SNAP_IDLE,
        SNAP_FOLLOW
    } snap_state_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_pulse_ch.sv
module gpio_pulse_ch
    import gpio_regbank_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wbit,
    input  logic style,
    output logic q
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    ch_state_t     st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          q_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
            q   <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            q   <= q_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        q_nx   = q;
        unique case (st)
            CH_IDLE: begin
                if (wr_hit) begin
                    q_nx = wbit;
                    if (wbit && style) begin
                        st_nx  = CH_ACTIVE;
                        cnt_nx = '0;
                    end
                end
            end
            CH_ACTIVE: begin
                if (wr_hit) begin
                    q_nx = wbit;
                    if (wbit && style) cnt_nx = '0;
                    else               st_nx  = CH_IDLE;
                end else if (!style) begin
                    st_nx = CH_IDLE;
                end else if (cnt == LAST) begin
                    q_nx  = 1'b0;
                    st_nx = CH_IDLE;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
        endcase
    end

    // R7: while a pulse is counting, the stored bit is high
    assert_pulse_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ACTIVE) |-> q);

    // R7: the final count with no intervening write ends the pulse
    assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_ACTIVE && cnt == LAST && !wr_hit && style) |=> !q);
endmodule

// File: rtl/gpio_snapshot.sv
module gpio_snapshot
    import gpio_regbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic         ext_low,
    input  logic         cap_en,
    output logic [W-1:0] snap
);
    snap_state_t st, st_nx;
    logic        grab;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SNAP_FILL1;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SNAP_FILL1:  st_nx = SNAP_FILL2;
            SNAP_FILL2:  st_nx = SNAP_TAKE;
            SNAP_TAKE:   st_nx = SNAP_IDLE;
            SNAP_IDLE:   if (cap_en && ext_low)    st_nx = SNAP_FOLLOW;
            SNAP_FOLLOW: if (!(cap_en && ext_low)) st_nx = SNAP_IDLE;
            default:     st_nx = SNAP_IDLE;
        endcase
    end

    assign grab = (st == SNAP_TAKE) || (st == SNAP_FOLLOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (grab) snap <= pins_s;
    end

    // R8: outside a capture state the snapshot holds
    assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SNAP_IDLE) |=> $stable(snap));

    // R9: with capture disabled, the external line cannot start a capture
    assert_ext_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SNAP_IDLE && !cap_en) |=> (st == SNAP_IDLE));
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int PIN_W     = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_n,
    input  logic              ext_cap_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [PIN_W-1:0]  rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    localparam logic [PIN_W-1:0] POL_RST = PIN_W'(8'hF0);
    localparam logic [PIN_W-1:0] DIR_RST = '1;

    logic [PIN_W-1:0] pins_s, out_q, pol_q, dir_q, style_q, snap_q, rd_mux;
    logic             ext_s;
    logic             wr_out;

    gpio_sync2 #(.W(PIN_W), .RST_VAL('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_s)
    );

    gpio_sync2 #(.W(1), .RST_VAL(1'b1)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_rst_n), .q(ext_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= POL_RST;
            dir_q   <= DIR_RST;
            style_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_POL:   pol_q   <= wdata;
                A_DIR:   dir_q   <= wdata;
                A_STYLE: style_q <= wdata;
                default: ;
            endcase
        end
    end

    assign wr_out = wr_en && (addr == A_OUT);

    for (genvar i = 0; i < PIN_W; i++) begin : g_ch
        gpio_pulse_ch #(.PULSE_LEN(PULSE_LEN)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_out),
            .wbit  (wdata[i]),
            .style (style_q[i]),
            .q     (out_q[i])
        );
    end

    gpio_snapshot #(.W(PIN_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_s (pins_s),
        .ext_low(!ext_s),
        .cap_en (ext_cap_en),
        .snap   (snap_q)
    );

    assign pin_out = out_q ^ pol_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        unique case (addr)
            A_PIN:   rd_mux = pins_s ^ pol_q;
            A_OUT:   rd_mux = out_q;
            A_POL:   rd_mux = pol_q;
            A_DIR:   rd_mux = dir_q;
            A_STYLE: rd_mux = style_q;
            A_SNAP:  rd_mux = snap_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R5: a direction write shows on the drive enables one edge later
    assert_dir_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR) |=> (pin_oe == ~$past(wdata)));

    // R10: reserved addresses read as zero
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > A_SNAP) |=> (rdata == '0));

    // R11: read data holds without a read strobe
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R10: a write to a read-only or reserved address leaves configuration intact
    assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_PIN || addr >= A_SNAP)) |=>
        ($stable(pol_q) && $stable(dir_q) && $stable(style_q)));
endmodule

// File: tb/sim_gpio_regbank.sv
module sim_gpio_regbank;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       ext_cap_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gpio_regbank #(.PIN_W(8), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .ext_cap_en(ext_cap_en),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd1, d); chk("R1 out", d, 8'h00);
        rd(3'd2, d); chk("R1 pol", d, 8'hF0);
        rd(3'd3, d); chk("R1 dir", d, 8'hFF);
        rd(3'd4, d); chk("R1 style", d, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        rd(3'd5, d); chk("R8 power-on snap", d, 8'hA5);
    endtask

    task automatic t_input;
        logic [7:0] d;
        @(negedge clk); pin_in = 8'h3C; idle(3);
        rd(3'd0, d); chk("R2 inv", d, 8'hCC);
        wr(3'd2, 8'h00); idle(1);
        rd(3'd0, d); chk("R2 plain", d, 8'h3C);
        @(negedge clk); pin_in = 8'h81; idle(3);
        rd(3'd0, d); chk("R2 change", d, 8'h81);
        rd(3'd5, d); chk("R8 snap holds", d, 8'hA5);
    endtask

    task automatic t_output;
        logic [7:0] d;
        wr(3'd3, 8'h0F);
        chk("R5 oe", pin_oe, 8'hF0);
        wr(3'd1, 8'h5A);
        chk("R4 out plain", pin_out, 8'h5A);
        chk("R6 level", pin_out, 8'h5A);
        idle(10);
        chk("R6 level held", pin_out, 8'h5A);
        @(negedge clk); pin_in = 8'h00; idle(3);
        rd(3'd1, d); chk("R3 stored", d, 8'h5A);
        wr(3'd2, 8'hFF);
        chk("R4 out inv", pin_out, 8'hA5);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
        chk("R5 all out", pin_oe, 8'hFF);
    endtask

    task automatic t_pulse;
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h01);
        for (int i = 0; i < PL; i++) begin
            chk("R7 pulse high", pin_out, 8'h01);
            @(negedge clk);
        end
        chk("R7 pulse end", pin_out, 8'h00);
        rd(3'd1, d); chk("R7 bit cleared", d, 8'h00);
    endtask

    task automatic t_ext;
        logic [7:0] d;
        ext_cap_en = 1'b1;
        @(negedge clk); pin_in = 8'h5A; idle(3);
        ext_rst_n = 1'b0; idle(6);
        ext_rst_n = 1'b1; idle(5);
        pin_in = 8'h11; idle(4);
        rd(3'd5, d); chk("R9 ext capture", d, 8'h5A);
        ext_cap_en = 1'b0;
        pin_in = 8'h77; idle(3);
        ext_rst_n = 1'b0; idle(6);
        ext_rst_n = 1'b1; idle(5);
        rd(3'd5, d); chk("R9 disabled", d, 8'h5A);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        wr(3'd1, 8'h00);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        wr(3'd0, 8'hFF);
        wr(3'd5, 8'h00);
        rd(3'd6, d); chk("R10 rsvd6", d, 8'h00);
        rd(3'd7, d); chk("R10 rsvd7", d, 8'h00);
        rd(3'd5, d); chk("R10 snap untouched", d, 8'h5A);
        rd(3'd1, d); chk("R10 out untouched", d, 8'h00);
        rd(3'd4, d); chk("R10 style untouched", d, 8'h01);
        rd(3'd0, d); chk("R10 pin read", d, 8'h77);
    endtask

    task automatic t_latency;
        logic [7:0] d;
        rd(3'd2, d); chk("R11 read", d, 8'h00);
        idle(3);
        chk("R11 hold", rdata, 8'h00);
        rd(3'd3, d);
        chk("R11 dir read", d, 8'h00);
        addr = 3'd4; idle(2);
        chk("R11 no strobe", rdata, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(6);
        t_reset;
        t_input;
        t_output;
        t_pulse;
        t_ext;
        t_reserved;
        t_latency;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule